// File: doc/BRIEF.md
# Eight-Channel Test Pattern Generator

This block sits between an eight-channel converter core and the serial framer that follows it. Normally it forwards each live conversion sample unchanged. When test mode is switched on, it replaces every outgoing sample with a digital pattern. The framer then receives known words and can check the whole data path without an analog source.

There are two patterns. In the fixed pattern, each channel has its own 16-bit word. In the ramp pattern, one shared accumulator climbs by a step that is taken from the pattern word of the highest channel. The ramp can advance once per channel frame or after every conversion strobe. By default the channel number is written into the low bits of each pattern word, so a receiver can tell which slot a word belongs to. A disable bit turns this off.

The output is registered on each conversion strobe and is held until the next strobe.

Top module: `test_pattern_gen`

## Requirements
- R1: After synchronous reset, `data_out` is 0, `out_valid` is 0 and all eight pattern words are 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `conv_strobe` was 1. Otherwise it is 0.
- R3: With `tp_en` = 0, the word registered on a strobe is `adc_data`, bit for bit.
- R4: With `tp_en` = 1, `tp_mode` = 3'b000 and `idx_dis` = 0, the word is the pattern word of `slot_ch`, with bits [2:0] replaced by `slot_ch`.
- R5: With `idx_dis` = 1, pattern words (fixed or ramp) are sent whole, with no channel number inserted.
- R6: With `tp_en` = 1 and `tp_mode` = 3'b010, the word is the ramp accumulator. The accumulator starts at 0.
- R7: The ramp step is the pattern word of channel 7, read at the moment of each advance.
- R8: With `upd_per_conv` = 1, the accumulator advances by the step on every strobe. The word registered on that strobe carries the value from before the advance.
- R9: With `upd_per_conv` = 0, the accumulator advances only on cycles with `frame_end` = 1. Strobes alone leave it unchanged.
- R10: The accumulator is 16 bits wide and wraps modulo 2^16.
- R11: The accumulator is cleared while the block is disabled or not in ramp mode. Enabling the block or re-entering ramp mode therefore restarts the ramp at 0.
- R12: Mode codes other than 3'b010 behave as the fixed pattern (3'b000).
- R13: A pattern write (`pat_wr_en`, `pat_wr_ch`, `pat_wr_data`) takes effect at the next clock edge. A strobe in the same cycle as the write still uses the old word.
- R14: `data_out` does not change in any cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tp_en | input | 1 | 1 selects the test pattern, 0 selects live data |
| tp_mode | input | 3 | Pattern select: 3'b010 is ramp, any other code is fixed |
| idx_dis | input | 1 | 1 turns off channel-number insertion |
| upd_per_conv | input | 1 | Ramp advance point: 1 advances on every strobe, 0 on frame end |
| pat_wr_en | input | 1 | Pattern word write strobe |
| pat_wr_ch | input | 3 | Channel whose pattern word is written |
| pat_wr_data | input | 16 | New pattern word |
| conv_strobe | input | 1 | A sample for slot `slot_ch` is presented this cycle |
| frame_end | input | 1 | Channel frame boundary pulse |
| slot_ch | input | 3 | Channel number of the current slot |
| adc_data | input | 16 | Live conversion sample |
| data_out | output | 16 | Registered outgoing word |
| out_valid | output | 1 | `data_out` was loaded on the previous edge |

## Verification
A wrong pattern word or a wrong accumulator value shows up on `data_out` one cycle after the next strobe that selects it. A bad step value or a wrong advance point only becomes visible one advance later, when the ramp difference is off. This is why the ramp sequences run across several frames and through a wrap. A missed clear of the accumulator is exposed by the first strobe after re-enabling the block or switching modes, since that word must carry a ramp value of 0. The bench's reference model is compared on every clock, so any of these differences is reported in the cycle it first appears.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int MODE_W = 3;

    // Pattern select codes; anything that is not the ramp code behaves as fixed.
    typedef enum logic [MODE_W-1:0] {
        MODE_FIXED = 3'b000,
        MODE_RAMP  = 3'b010
    } tp_mode_e;

    // Where the ramp accumulator advances.
    typedef enum logic {
        ADV_AT_FRAME = 1'b0,
        ADV_AT_CONV  = 1'b1
    } adv_point_e;

    // Static configuration seen by the datapath.
    typedef struct packed {
        logic               en;
        logic [MODE_W-1:0]  mode;
        logic               idx_dis;
        adv_point_e         adv_point;
    } tp_cfg_t;

    function automatic logic ramp_selected(input tp_cfg_t c);
        return c.en && (c.mode == MODE_RAMP);
    endfunction

    function automatic logic advance_now(input adv_point_e p,
                                         input logic conv,
                                         input logic frame);
        return (p == ADV_AT_CONV) ? conv : frame;
    endfunction

endpackage

// File: rtl/tpg_pattern_bank.sv
module tpg_pattern_bank #(
    parameter int NCH = 8,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW-1:0] rd_ch,
    output logic [DW-1:0]  rd_data,
    output logic [DW-1:0]  step_word
);

    logic [DW-1:0] words [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (wr_en && (wr_ch == CHW'(g))) begin
                words[g] <= wr_data;
            end
        end
    end

    assign rd_data   = words[rd_ch];
    assign step_word = words[NCH-1];

    AST_STEP_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ch == CHW'(NCH-1)) |=> (step_word == $past(wr_data))); // R7

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_ch == wr_ch && $stable(rd_ch)) |=> (rd_data == $past(wr_data))); // R13

endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          advance,
    input  logic [DW-1:0] step,
    output logic [DW-1:0] acc
);

    logic [DW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= acc_q + step;
        end
    end

    assign acc = acc_q;

    AST_RAMP_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !active |=> (acc == '0)); // R11

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && advance) |=> (acc == DW'($past(acc) + $past(step)))); // R10

    AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !advance) |=> $stable(acc)); // R9

endmodule

// File: rtl/tpg_out_sel.sv
module tpg_out_sel
    import tpg_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  tp_cfg_t        cfg,
    input  logic           conv_strobe,
    input  logic [CHW-1:0] slot_ch,
    input  logic [DW-1:0]  adc_data,
    input  logic [DW-1:0]  fixed_word,
    input  logic [DW-1:0]  ramp_word,
    output logic [DW-1:0]  data_out,
    output logic           out_valid
);

    logic [DW-1:0] pat_raw;
    logic [DW-1:0] pat_tagged;
    logic [DW-1:0] next_word;

    always_comb begin
        pat_raw    = ramp_selected(cfg) ? ramp_word : fixed_word;
        pat_tagged = cfg.idx_dis ? pat_raw : {pat_raw[DW-1:CHW], slot_ch};
        next_word  = cfg.en ? pat_tagged : adc_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= conv_strobe;
            if (conv_strobe) begin
                data_out <= next_word;
            end
        end
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        conv_strobe |=> out_valid); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !conv_strobe |=> !out_valid); // R2

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !conv_strobe |=> $stable(data_out)); // R14

    AST_LIVE_PASS: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && !cfg.en) |=> (data_out == $past(adc_data))); // R3

    AST_INDEX_TAG: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && cfg.en && !cfg.idx_dis) |=> (data_out[CHW-1:0] == $past(slot_ch))); // R4

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tp_en,
    input  logic [MODE_W-1:0] tp_mode,
    input  logic              idx_dis,
    input  logic              upd_per_conv,
    input  logic              pat_wr_en,
    input  logic [CHW-1:0]    pat_wr_ch,
    input  logic [DW-1:0]     pat_wr_data,
    input  logic              conv_strobe,
    input  logic              frame_end,
    input  logic [CHW-1:0]    slot_ch,
    input  logic [DW-1:0]     adc_data,
    output logic [DW-1:0]     data_out,
    output logic              out_valid
);

    tp_cfg_t       cfg;
    logic [DW-1:0] fixed_word;
    logic [DW-1:0] step_word;
    logic [DW-1:0] ramp_word;
    logic          ramp_on;
    logic          ramp_adv;

    always_comb begin
        cfg.en        = tp_en;
        cfg.mode      = tp_mode;
        cfg.idx_dis   = idx_dis;
        cfg.adv_point = adv_point_e'(upd_per_conv);
        ramp_on       = ramp_selected(cfg);
        ramp_adv      = advance_now(cfg.adv_point, conv_strobe, frame_end);
    end

    tpg_pattern_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (pat_wr_en),
        .wr_ch     (pat_wr_ch),
        .wr_data   (pat_wr_data),
        .rd_ch     (slot_ch),
        .rd_data   (fixed_word),
        .step_word (step_word)
    );

    tpg_ramp #(.DW(DW)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .active  (ramp_on),
        .advance (ramp_adv),
        .step    (step_word),
        .acc     (ramp_word)
    );

    tpg_out_sel #(.NCH(NCH), .DW(DW)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .conv_strobe (conv_strobe),
        .slot_ch     (slot_ch),
        .adc_data    (adc_data),
        .fixed_word  (fixed_word),
        .ramp_word   (ramp_word),
        .data_out    (data_out),
        .out_valid   (out_valid)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (data_out == '0 && !out_valid)); // R1

    AST_RAMP_RESTART: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && ramp_on && !$past(ramp_on) && idx_dis) |=> (data_out == '0)); // R6

endmodule

// File: tb/sim_test_pattern_gen.sv
`timescale 1ns/1ps
module sim_test_pattern_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tp_en = 1'b0;
    logic [2:0]  tp_mode = 3'b000;
    logic        idx_dis = 1'b0;
    logic        upd_per_conv = 1'b0;
    logic        pat_wr_en = 1'b0;
    logic [2:0]  pat_wr_ch = '0;
    logic [15:0] pat_wr_data = '0;
    logic        conv_strobe = 1'b0;
    logic        frame_end = 1'b0;
    logic [2:0]  slot_ch = '0;
    logic [15:0] adc_data = '0;
    logic [15:0] data_out;
    logic        out_valid;

    always #2.5 clk = ~clk;

    test_pattern_gen u0 (
        .clk(clk), .rst(rst), .tp_en(tp_en), .tp_mode(tp_mode), .idx_dis(idx_dis),
        .upd_per_conv(upd_per_conv), .pat_wr_en(pat_wr_en), .pat_wr_ch(pat_wr_ch),
        .pat_wr_data(pat_wr_data), .conv_strobe(conv_strobe), .frame_end(frame_end),
        .slot_ch(slot_ch), .adc_data(adc_data), .data_out(data_out), .out_valid(out_valid)
    );

    // Behavioural reference model
    int    pat [8];
    int    acc;
    int    exp_data;
    bit    exp_valid;
    bit    started;
    int    checks;
    int    fails;
    string cur_req = "R1";

    always @(posedge clk) begin
        int w;
        if (rst) begin
            for (int i = 0; i < 8; i++) pat[i] = 0;
            acc = 0; exp_data = 0; exp_valid = 0;
        end else begin
            if (!tp_en) w = adc_data;
            else if (tp_mode == 3'b010) w = acc;
            else w = pat[slot_ch];
            if (tp_en && !idx_dis) w = (w & 16'hFFF8) | slot_ch;
            exp_valid = conv_strobe;
            if (conv_strobe) exp_data = w;
            if (!(tp_en && tp_mode == 3'b010)) acc = 0;
            else if (upd_per_conv ? conv_strobe : frame_end) acc = (acc + pat[7]) % 65536;
            if (pat_wr_en) pat[pat_wr_ch] = pat_wr_data;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (out_valid !== exp_valid) begin
                fails++;
                $display("FAIL R2 out_valid actual=%0b expected=%0b t=%0t", out_valid, exp_valid, $time);
            end
            checks++;
            if (data_out !== 16'(exp_data)) begin
                fails++;
                $display("FAIL %s data_out actual=%h expected=%h t=%0t",
                         exp_valid ? cur_req : "R14", data_out, 16'(exp_data), $time);
            end
        end
    end

    task automatic cyc(input logic s, input logic [2:0] ch, input logic [15:0] d, input logic fe);
        conv_strobe = s; slot_ch = ch; adc_data = d; frame_end = fe;
        @(negedge clk);
        conv_strobe = 0; frame_end = 0;
    endtask

    task automatic wr(input logic [2:0] ch, input logic [15:0] d);
        pat_wr_en = 1; pat_wr_ch = ch; pat_wr_data = d;
        @(negedge clk);
        pat_wr_en = 0;
    endtask

    task automatic frame(input int gap);
        for (int c = 0; c < 8; c++) begin
            cyc(1, 3'(c), 16'h0, 0);
            for (int k = 0; k < gap; k++) cyc(0, 3'(c), 16'h0, 0);
        end
        cyc(0, 3'd0, 16'h0, 1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        rst = 0;
        @(negedge clk);

        // Live pass-through
        cur_req = "R3";
        cyc(1, 3'd2, 16'hA5C3, 0);
        cyc(0, 3'd2, 16'h1234, 0);
        cyc(0, 3'd2, 16'h1234, 0);
        cyc(1, 3'd7, 16'hFFFF, 0);
        cyc(1, 3'd1, 16'h0007, 0);

        // Load fixed words
        for (int i = 0; i < 8; i++) wr(3'(i), 16'(16'h1111 * (i + 1) + 5));

        cur_req = "R4";
        tp_en = 1;
        for (int i = 0; i < 8; i++) cyc(1, 3'(7 - i), 16'hDEAD, 0);

        cur_req = "R5";
        idx_dis = 1;
        for (int i = 0; i < 8; i++) cyc(1, 3'(i), 16'hBEEF, 0);

        cur_req = "R12";
        tp_mode = 3'b101;
        cyc(1, 3'd3, 16'h0, 0);
        tp_mode = 3'b111;
        cyc(1, 3'd6, 16'h0, 0);
        tp_mode = 3'b001;
        idx_dis = 0;
        cyc(1, 3'd4, 16'h0, 0);
        tp_mode = 3'b000;

        // Write and strobe in the same cycle
        cur_req = "R13";
        pat_wr_en = 1; pat_wr_ch = 3'd5; pat_wr_data = 16'h7A7F;
        cyc(1, 3'd5, 16'h0, 0);
        pat_wr_en = 0;
        cyc(1, 3'd5, 16'h0, 0);

        // Ramp, advance on every strobe
        cur_req = "R8";
        wr(3'd7, 16'h0010);
        tp_mode = 3'b010; upd_per_conv = 1; idx_dis = 1;
        cyc(0, 3'd0, 16'h0, 0);
        cur_req = "R6";
        cyc(1, 3'd0, 16'h0, 0);
        cur_req = "R8";
        for (int i = 1; i < 10; i++) cyc(1, 3'(i), 16'h0, 0);
        idx_dis = 0;
        for (int i = 0; i < 4; i++) cyc(1, 3'(i), 16'h0, 0);

        // Step change mid-run
        cur_req = "R7";
        wr(3'd7, 16'h0123);
        for (int i = 0; i < 5; i++) cyc(1, 3'(i), 16'h0, 0);

        // Frame-boundary advance
        cur_req = "R9";
        upd_per_conv = 0; idx_dis = 1;
        frame(0);
        frame(1);
        cyc(1, 3'd0, 16'h0, 1);
        cyc(1, 3'd1, 16'h0, 0);

        // Wrap
        cur_req = "R10";
        upd_per_conv = 1;
        wr(3'd7, 16'hF001);
        for (int i = 0; i < 6; i++) cyc(1, 3'(i), 16'h0, 0);

        // Restart after disable and after a mode change
        cur_req = "R11";
        tp_en = 0;
        cyc(1, 3'd0, 16'h5555, 0);
        tp_en = 1;
        cyc(1, 3'd0, 16'h0, 0);
        cyc(1, 3'd1, 16'h0, 0);
        tp_mode = 3'b000;
        cyc(1, 3'd2, 16'h0, 0);
        tp_mode = 3'b010;
        cyc(1, 3'd3, 16'h0, 0);
        cyc(1, 3'd4, 16'h0, 0);

        // Reset in the middle of a run
        cur_req = "R1";
        rst = 1;
        cyc(0, 3'd0, 16'h0, 0);
        cyc(0, 3'd0, 16'h0, 0);
        rst = 0;
        cyc(0, 3'd0, 16'h0, 0);
        tp_mode = 3'b000;
        cyc(1, 3'd7, 16'h0, 0);
        cyc(0, 3'd0, 16'h0, 0);

        finish_run();
    end

endmodule